// File: doc/BRIEF.md
# Spread-Spectrum Triangle Profile Generator

This block drives the frequency-offset word of a clock synthesizer's fractional feedback divider. A triangular offset profile spreads the energy of the synthesized clock over a band and lowers its peak emission. Four strap bits are captured once, on the first strap-valid pulse after reset. They choose the spread kind (down, centre or asymmetric) and its limits. The block then sweeps the offset between the chosen upper and lower limits, completing one triangle every 512 reference clocks.

The offset is given in two forms. The coarse form is a signed integer in steps of 0.125 %. The fine form carries 8 more fractional bits, so the ramp climbs smoothly rather than in 0.125 % steps. Strap codes that are not assigned, including the all-ones value that floating straps produce, leave modulation off with a zero offset.

Top module: `ssc_profile_gen`

## Requirements
- R1: From reset until the first clock edge where `strap_vld_i` is high, `ofs_fine_o` and `ofs_coarse_o` are zero, `spread_on_o` is low and `spread_kind_o` is 0 (off).
- R2: The strap code `{strap_i[3],strap_i[2],strap_i[1],strap_i[0]}` is captured on the first `strap_vld_i` edge only. Later strap changes and later or held strap-valid pulses change neither the kind nor the ramp's progress.
- R3: Codes 4'b0110, 4'b1001 and 4'b1100 select down spread, kind 1. The upper limit is 0 and the lower limits are −30, −28 and −26 coarse units respectively.
- R4: Codes 4'b1010, 4'b1101 and 4'b1110 select asymmetric spread, kind 3, with upper/lower limits +1/−29, +1/−27 and +2/−28 coarse units.
- R5: Codes 4'b0000, 4'b0001 and 4'b0010 select centre spread, kind 2, with limits ±13, ±14 and ±15 coarse units.
- R6: Code 4'b0011 and every code not listed in R3–R5 (4'b1111 among them) give kind 0 with `spread_on_o` low and both offsets at zero.
- R7: When spread is active, let p be the number of clock edges since the capture edge, taken modulo 512 (p = 0 just after capture). The fine offset is hi·256 − (hi−lo)·p for p < 256 and lo·256 + (hi−lo)·(p−256) otherwise. The ramp therefore starts at the upper limit and repeats every 512 clocks.
- R8: `ofs_fine_o` is two's complement in units of 0.125 %/256. `ofs_coarse_o` equals floor(`ofs_fine_o`/256).
- R9: `spread_on_o` is high exactly when a strap code has been captured and selects kind 1, 2 or 3. `spread_kind_o` holds that kind (0 off, 1 down, 2 centre, 3 asymmetric).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strap_i | input | 4 | Strap code, bit 3 captured once as the power-up-only strap |
| strap_vld_i | input | 1 | Strap code valid; the first high edge captures it |
| ofs_fine_o | output | 16 | Signed offset, 0.125 %/256 per unit |
| ofs_coarse_o | output | 6 | Signed offset, 0.125 % per unit (floor) |
| spread_on_o | output | 1 | Modulation active |
| spread_kind_o | output | 2 | 0 off, 1 down, 2 centre, 3 asymmetric |

## Verification
A phase counter that skips or stalls shows up at once as a fine-offset step different from the span (hi−lo). It also moves the turning points away from phases 256 and 512, so the first sampled phase after the fault disagrees. A wrong decode entry or a re-capture of the strap is visible on the first cycle after capture, through the kind and the starting upper limit. A lost capture flag shows as a kind change or a phase restart at the next strap-valid pulse.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
   // Coarse limit width: holds -32..31 steps of 0.125 %
   localparam int SSC_LIM_W = 6;

   typedef enum logic [1:0] {
      SSC_OFF    = 2'd0,
      SSC_DOWN   = 2'd1,
      SSC_CENTRE = 2'd2,
      SSC_ASYM   = 2'd3
   } ssc_kind_e;

   typedef struct packed {
      ssc_kind_e                     kind;
      logic signed [SSC_LIM_W-1:0]   hi;
      logic signed [SSC_LIM_W-1:0]   lo;
   } ssc_cfg_t;
endpackage

// File: rtl/ssc_strap_decode.sv
module ssc_strap_decode
   import ssc_pkg::*;
(
   input  logic [3:0] strap_i,
   output ssc_cfg_t   cfg_o
);
   function automatic ssc_cfg_t mk(input ssc_kind_e k, input int h, input int l);
      ssc_cfg_t c;
      c.kind = k;
      c.hi   = SSC_LIM_W'(h);
      c.lo   = SSC_LIM_W'(l);
      return c;
   endfunction

   always_comb begin
      unique case (strap_i)
         4'b0000: cfg_o = mk(SSC_CENTRE, 13, -13);
         4'b0001: cfg_o = mk(SSC_CENTRE, 14, -14);
         4'b0010: cfg_o = mk(SSC_CENTRE, 15, -15);
         4'b0110: cfg_o = mk(SSC_DOWN,    0, -30);
         4'b1001: cfg_o = mk(SSC_DOWN,    0, -28);
         4'b1100: cfg_o = mk(SSC_DOWN,    0, -26);
         4'b1010: cfg_o = mk(SSC_ASYM,    1, -29);
         4'b1101: cfg_o = mk(SSC_ASYM,    1, -27);
         4'b1110: cfg_o = mk(SSC_ASYM,    2, -28);
         default: cfg_o = mk(SSC_OFF,     0,   0);
      endcase
   end
endmodule

// File: rtl/ssc_phase_cnt.sv
module ssc_phase_cnt #(
   parameter int PHASE_W = 9
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               clr_i,
   input  logic               en_i,
   output logic [PHASE_W-1:0] phase_o
);
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         phase_o <= '0;
      end else if (clr_i) begin
         phase_o <= '0;
      end else if (en_i) begin
         phase_o <= phase_o + 1'b1;
      end
   end
endmodule

// File: rtl/ssc_ramp.sv
module ssc_ramp
   import ssc_pkg::*;
#(
   parameter int PHASE_W = 9,
   parameter int FINE_W  = 16
) (
   input  logic [PHASE_W-1:0]          phase_i,
   input  logic signed [SSC_LIM_W-1:0] hi_i,
   input  logic signed [SSC_LIM_W-1:0] lo_i,
   output logic signed [FINE_W-1:0]    fine_o
);
   localparam int HALF_W = PHASE_W - 1;

   logic signed [FINE_W-1:0] hi_ext, lo_ext, span, pos, prod;

   always_comb begin
      hi_ext = {{(FINE_W-SSC_LIM_W){hi_i[SSC_LIM_W-1]}}, hi_i};
      lo_ext = {{(FINE_W-SSC_LIM_W){lo_i[SSC_LIM_W-1]}}, lo_i};
      span   = hi_ext - lo_ext;
      pos    = {{(FINE_W-HALF_W){1'b0}}, phase_i[HALF_W-1:0]};
      prod   = span * pos;
      if (phase_i[PHASE_W-1]) begin
         fine_o = (lo_ext <<< HALF_W) + prod;   // rising half
      end else begin
         fine_o = (hi_ext <<< HALF_W) - prod;   // falling half
      end
   end
endmodule

// File: rtl/ssc_profile_gen.sv
module ssc_profile_gen
   import ssc_pkg::*;
#(
   parameter int PHASE_W = 9,
   parameter int FINE_W  = 16
) (
   input  logic                          clk_i,
   input  logic                          rst_ni,
   input  logic [3:0]                    strap_i,
   input  logic                          strap_vld_i,
   output logic signed [FINE_W-1:0]      ofs_fine_o,
   output logic signed [SSC_LIM_W-1:0]   ofs_coarse_o,
   output logic                          spread_on_o,
   output logic [1:0]                    spread_kind_o
);
   localparam int HALF_W = PHASE_W - 1;

   generate
      if (PHASE_W < 2) begin : g_chk_phase
         $error("ssc_profile_gen: PHASE_W must be at least 2");
      end
      if (FINE_W < SSC_LIM_W + HALF_W) begin : g_chk_fine
         $error("ssc_profile_gen: FINE_W too narrow for limit and fraction");
      end
   endgenerate

   ssc_cfg_t           cfg_d, cfg_q;
   logic               latched_q;
   logic               take;
   logic               active;
   logic [PHASE_W-1:0] phase;
   logic signed [FINE_W-1:0] ramp_fine;

   assign take = strap_vld_i && !latched_q;

   ssc_strap_decode u_dec (
      .strap_i (strap_i),
      .cfg_o   (cfg_d)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         latched_q <= 1'b0;
         cfg_q     <= '{kind: SSC_OFF, hi: '0, lo: '0};
      end else if (take) begin
         latched_q <= 1'b1;
         cfg_q     <= cfg_d;
      end
   end

   assign active = latched_q && (cfg_q.kind != SSC_OFF);

   ssc_phase_cnt #(.PHASE_W(PHASE_W)) u_phase (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (take),
      .en_i    (active),
      .phase_o (phase)
   );

   ssc_ramp #(.PHASE_W(PHASE_W), .FINE_W(FINE_W)) u_ramp (
      .phase_i (phase),
      .hi_i    (cfg_q.hi),
      .lo_i    (cfg_q.lo),
      .fine_o  (ramp_fine)
   );

   assign ofs_fine_o    = active ? ramp_fine : '0;
   assign ofs_coarse_o  = ofs_fine_o[HALF_W +: SSC_LIM_W];
   assign spread_on_o   = active;
   assign spread_kind_o = cfg_q.kind;
endmodule

// File: rtl/ssc_profile_chk.sv
module ssc_profile_chk
   import ssc_pkg::*;
#(
   parameter int PHASE_W = 9,
   parameter int FINE_W  = 16
) (
   input logic                        clk_i,
   input logic                        rst_ni,
   input logic                        strap_vld_i,
   input logic signed [FINE_W-1:0]    ofs_fine_o,
   input logic                        spread_on_o,
   input logic [1:0]                  spread_kind_o
);
   localparam int HALF_W = PHASE_W - 1;
   localparam logic signed [FINE_W-1:0] CTR_MAX  = FINE_W'(15 <<< HALF_W);
   localparam logic signed [FINE_W-1:0] CTR_MIN  = FINE_W'(-(15 <<< HALF_W));
   localparam logic signed [FINE_W-1:0] ASY_MAX  = FINE_W'(2 <<< HALF_W);
   localparam logic signed [FINE_W-1:0] ASY_MIN  = FINE_W'(-(29 <<< HALF_W));
   localparam logic signed [FINE_W-1:0] STEP_MAX = FINE_W'(30);
   localparam logic signed [FINE_W-1:0] ZERO     = '0;

   logic                     seen_q;
   logic signed [FINE_W-1:0] prev_q;
   logic signed [FINE_W-1:0] delta;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         seen_q <= 1'b0;
         prev_q <= '0;
      end else begin
         if (strap_vld_i) seen_q <= 1'b1;
         prev_q <= ofs_fine_o;
      end
   end

   assign delta = ofs_fine_o - prev_q;

   a_r1_idle_before_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !seen_q |-> (ofs_fine_o == ZERO && !spread_on_o && spread_kind_o == 2'd0));

   a_r2_kind_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (seen_q && $past(seen_q)) |-> $stable(spread_kind_o));

   a_r3_down_not_positive: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (spread_kind_o == 2'd1) |-> (ofs_fine_o <= ZERO));

   a_r4_asym_bounds: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (spread_kind_o == 2'd3) |-> (ofs_fine_o <= ASY_MAX && ofs_fine_o >= ASY_MIN));

   a_r5_centre_bounds: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (spread_kind_o == 2'd2) |-> (ofs_fine_o <= CTR_MAX && ofs_fine_o >= CTR_MIN));

   a_r6_off_is_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (spread_kind_o == 2'd0) |-> (!spread_on_o && ofs_fine_o == ZERO));

   a_r7_starts_at_upper: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(spread_on_o) |-> (ofs_fine_o >= ZERO));

   a_r8_step_by_span: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (spread_on_o && $past(spread_on_o)) |->
         (delta != ZERO && delta <= STEP_MAX && delta >= -STEP_MAX));

   a_r9_on_matches_kind: assert property (@(posedge clk_i) disable iff (!rst_ni)
      spread_on_o |-> (spread_kind_o != 2'd0));
endmodule

bind ssc_profile_gen ssc_profile_chk #(.PHASE_W(PHASE_W), .FINE_W(FINE_W)) u_chk (
   .clk_i         (clk_i),
   .rst_ni        (rst_ni),
   .strap_vld_i   (strap_vld_i),
   .ofs_fine_o    (ofs_fine_o),
   .spread_on_o   (spread_on_o),
   .spread_kind_o (spread_kind_o)
);

// File: tb/ssc_profile_gen_tb.sv
`timescale 1ns/1ps
module ssc_profile_gen_tb;
   localparam int HALF_NS = 10;   // 50 MHz
   localparam int PERIOD  = 512;

   // per code 0..15: kind, upper limit, lower limit (coarse units)
   localparam int TBL [16][3] = '{
      '{2, 13, -13}, '{2, 14, -14}, '{2, 15, -15}, '{0, 0, 0},
      '{0, 0, 0},    '{0, 0, 0},    '{1, 0, -30},  '{0, 0, 0},
      '{0, 0, 0},    '{1, 0, -28},  '{3, 1, -29},  '{0, 0, 0},
      '{1, 0, -26},  '{3, 1, -27},  '{3, 2, -28},  '{0, 0, 0}
   };
   localparam int NSAMP = 8;
   localparam int SAMP [NSAMP] = '{0, 1, 128, 255, 256, 300, 511, 512};

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [3:0]        strap = 4'hF;
   logic              vld = 1'b0;
   logic signed [15:0] fine;
   logic signed [5:0]  coarse;
   logic              on;
   logic [1:0]        kind;

   int n_chk = 0;
   int n_bad = 0;

   always #(HALF_NS) clk = ~clk;

   ssc_profile_gen u_dut (
      .clk_i         (clk),
      .rst_ni        (rst_n),
      .strap_i       (strap),
      .strap_vld_i   (vld),
      .ofs_fine_o    (fine),
      .ofs_coarse_o  (coarse),
      .spread_on_o   (on),
      .spread_kind_o (kind)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int exp_fine(input int hi, input int lo, input int p);
      int pm = p % PERIOD;
      if (pm < PERIOD/2) return hi*256 - (hi-lo)*pm;
      return lo*256 + (hi-lo)*(pm - PERIOD/2);
   endfunction

   function automatic int floor256(input int f);
      if (f >= 0) return f / 256;
      return -((-f + 255) / 256);
   endfunction

   function automatic string kind_req(input int k);
      case (k)
         1: return "R3";
         2: return "R5";
         3: return "R4";
         default: return "R6";
      endcase
   endfunction

   task automatic do_reset();
      rst_n = 1'b0;
      vld   = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // latch a code at the next posedge; returns at negedge with p = 0
   task automatic capture(input logic [3:0] code);
      strap = code;
      vld   = 1'b1;
      @(negedge clk);
      vld   = 1'b0;
   endtask

   task automatic check_state(input int k, input int hi, input int lo, input int p, input string tag);
      int ef;
      ef = (k == 0) ? 0 : exp_fine(hi, lo, p);
      chk(kind_req(k), {tag, " kind (R9)"}, int'(kind), k);
      chk("R9", {tag, " spread_on"}, int'(on), (k != 0) ? 1 : 0);
      chk("R7", {tag, " fine"}, int'(fine), ef);
      chk("R8", {tag, " coarse"}, int'(coarse), floor256(ef));
   endtask

   initial begin : watchdog
      #(2 * HALF_NS * 200000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin : main
      // R1: reset state while held in reset and after release
      #(3);
      chk("R1", "fine in reset", int'(fine), 0);
      chk("R1", "on in reset", int'(on), 0);
      do_reset();

      // table walk: every strap code
      for (int c = 0; c < 16; c++) begin
         int k, hi, lo, pcur;
         k = TBL[c][0]; hi = TBL[c][1]; lo = TBL[c][2];
         do_reset();
         strap = 4'(c);
         repeat (2) @(negedge clk);
         chk("R1", $sformatf("code %0d pre-capture fine", c), int'(fine), 0);
         chk("R1", $sformatf("code %0d pre-capture on", c), int'(on), 0);
         chk("R1", $sformatf("code %0d pre-capture kind", c), int'(kind), 0);
         capture(4'(c));
         pcur = 0;
         for (int s = 0; s < NSAMP; s++) begin
            repeat (SAMP[s] - pcur) @(negedge clk);
            pcur = SAMP[s];
            check_state(k, hi, lo, pcur, $sformatf("code %0d p %0d", c, pcur));
         end
      end

      // R2: capture ignores earlier strap values; later pulses ignored
      begin
         do_reset();
         strap = 4'b0010;
         repeat (3) @(negedge clk);
         capture(4'b1101);
         check_state(3, 1, -27, 0, "R2 first capture");
         repeat (40) @(negedge clk);
         strap = 4'b0110;
         vld   = 1'b1;
         repeat (20) @(negedge clk);   // held valid with another code
         vld   = 1'b0;
         strap = 4'b0000;
         @(negedge clk);
         check_state(3, 1, -27, 61, "R2 after re-pulse");
         chk("R2", "kind after re-pulse", int'(kind), 3);
      end

      // R6: floating straps (all ones) keep spread off for a long time
      begin
         do_reset();
         capture(4'b1111);
         repeat (300) @(negedge clk);
         chk("R6", "default straps fine", int'(fine), 0);
         chk("R6", "default straps on", int'(on), 0);
         chk("R6", "default straps kind", int'(kind), 0);
         // a later valid pulse with a real code is ignored
         capture(4'b0110);
         chk("R2", "off stays off after re-pulse", int'(kind), 0);
      end

      // R1/R7: reset mid-ramp returns to idle, then ramp restarts at upper
      begin
         do_reset();
         capture(4'b0010);
         repeat (77) @(negedge clk);
         check_state(2, 15, -15, 77, "R7 mid ramp");
         do_reset();
         chk("R1", "idle after mid-ramp reset", int'(fine), 0);
         chk("R1", "on after mid-ramp reset", int'(on), 0);
         capture(4'b1110);
         check_state(3, 2, -28, 0, "R7 restart at upper");
         repeat (2*PERIOD + 5) @(negedge clk);
         check_state(3, 2, -28, 2*PERIOD + 5, "R7 third period");
      end

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule